// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a virtual-to-physical translation after a lookup miss by reading a two-level page table held in memory. A client hands it a 32-bit virtual address, a read/write flag and the physical base of the top-level table. The walker then issues at most two entry reads through a memory read port that allows one request in flight.

Each table fills exactly one 4 KB page and holds 1024 four-byte entries. The top ten virtual bits select the top-level entry. That entry names the page holding the second-level table, and the next ten bits select the entry within it. The low twelve bits are the page offset and are copied into the physical address unchanged.

An entry with its valid bit clear ends the walk at once with a fault, so unused parts of the tree never have to exist in memory. A write to a leaf page that is not writable also faults. Results are returned over a valid/ready handshake.

Top module: `pt_walk_engine`

## Requirements
- R1: On success, res_paddr equals the leaf frame number in bits 31:12 followed by req_vaddr[11:0] unchanged in bits 11:0.
- R2: The first read address is {root_base[31:12], 12'h000} + 4 * req_vaddr[31:22]. The low 12 bits of root_base are ignored, and root_base is sampled when the request is accepted.
- R3: The second read address is {E1[31:12], 12'h000} + 4 * req_vaddr[21:12], where E1 is the first-level entry. Bit 1 of E1 has no effect.
- R4: Entry bit 0 is the valid flag. If it is 0 in the first-level entry, the result is a fault after exactly one memory read.
- R5: If bit 0 is 0 in the second-level entry, the result is a fault after exactly two memory reads.
- R6: Entry bit 1 is the writable flag. A write request whose leaf entry has bit 1 = 0 faults. A read request to the same page succeeds with res_writable = 0.
- R7: On success, res_frame equals leaf entry bits 31:12 and res_writable equals leaf entry bit 1. A fault reports res_frame = 0, res_writable = 0 and res_paddr = 0.
- R8: req_ready is high only while no walk is in progress or pending delivery. A request held during a walk is neither accepted nor does it alter the walk.
- R9: mem_rd_valid, once raised, stays high with mem_rd_addr unchanged until mem_rd_ready is seen.
- R10: res_valid, once raised, stays high with all result fields unchanged until res_ready is seen.
- R11: After reset, req_ready = 1, mem_rd_valid = 0 and res_valid = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_is_write | input | 1 | Access is a write |
| root_base | input | 32 | Physical base of the top-level table |
| mem_rd_valid | output | 1 | Entry read request |
| mem_rd_ready | input | 1 | Memory takes the read request |
| mem_rd_addr | output | 32 | Physical address of the entry to read |
| mem_rsp_valid | input | 1 | Read data returned (one cycle) |
| mem_rsp_data | input | 32 | Entry word returned by memory |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Client takes the result |
| res_paddr | output | 32 | Translated physical address |
| res_frame | output | 20 | Physical frame number |
| res_writable | output | 1 | Page may be written |
| res_fault | output | 1 | Walk ended in a fault |

## Verification
The main sweep covers a grid of first-level and second-level indices that includes indices 0 and 1023, with both read and write accesses. The bench-side table model derives validity and writability arithmetically from the indices, so the sweep separates faults at the first level, faults at the second level, permission faults and successes. It also confirms that each fault case makes the right number of reads, one or two. Alternating a root value with and without low-order garbage shows that those bits are ignored. A second, all-invalid root shows that the walk reads from the root it was given. Varying the memory's ready pattern and response latency, stalling the result handshake, and holding a second request during a walk exercise the handshake rules.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_READ_L1 = 3'd1,
    ST_WAIT_L1 = 3'd2,
    ST_READ_L2 = 3'd3,
    ST_WAIT_L2 = 3'd4,
    ST_DONE    = 3'd5
  } walk_state_t;

  localparam int PTE_VALID_BIT = 0;
  localparam int PTE_WRITE_BIT = 1;
endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
  parameter int VA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int IDX_W     = 10,
  parameter int PTE_SHIFT = 2,
  parameter int FRAME_W   = 20,
  localparam int PA_W     = FRAME_W + PAGE_BITS
) (
  input  logic [VA_W-1:0]    vaddr,
  input  logic [FRAME_W-1:0] table_frame,
  input  logic               second_level,
  output logic [PA_W-1:0]    entry_addr
);
  logic [IDX_W-1:0] idx_hi;
  logic [IDX_W-1:0] idx_lo;
  logic [IDX_W-1:0] idx_sel;
  logic [PAGE_BITS-1:0] unused_offset;

  assign idx_hi        = vaddr[VA_W-1 -: IDX_W];
  assign idx_lo        = vaddr[PAGE_BITS +: IDX_W];
  assign unused_offset = vaddr[PAGE_BITS-1:0];
  assign idx_sel       = second_level ? idx_lo : idx_hi;
  // table is page aligned and index*entry size stays inside the page
  assign entry_addr    = {table_frame, idx_sel, {PTE_SHIFT{1'b0}}};
endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check #(
  parameter int PTE_W     = 32,
  parameter int PAGE_BITS = 12,
  parameter int FRAME_W   = 20
) (
  input  logic [PTE_W-1:0]   entry,
  input  logic               leaf_level,
  input  logic               is_write,
  output logic               fault,
  output logic [FRAME_W-1:0] frame,
  output logic               writable
);
  import ptw_pkg::*;
  logic present;
  logic [PAGE_BITS-3:0] unused_bits;

  assign present     = entry[PTE_VALID_BIT];
  assign writable    = entry[PTE_WRITE_BIT];
  assign frame       = entry[PAGE_BITS +: FRAME_W];
  assign unused_bits = entry[PAGE_BITS-1:2];
  // pointer entries only need the valid bit; leaf entries also gate writes
  assign fault       = !present || (leaf_level && is_write && !writable);
endmodule

// File: rtl/pt_walk_engine.sv
module pt_walk_engine #(
  parameter int VA_W      = 32,
  parameter int PA_W      = 32,
  parameter int PAGE_BITS = 12,
  parameter int PTE_BYTES = 4,
  localparam int PTE_W     = 8 * PTE_BYTES,
  localparam int PTE_SHIFT = $clog2(PTE_BYTES),
  localparam int IDX_W     = PAGE_BITS - PTE_SHIFT,
  localparam int FRAME_W   = PA_W - PAGE_BITS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VA_W-1:0]    req_vaddr,
  input  logic               req_is_write,
  input  logic [PA_W-1:0]    root_base,
  output logic               mem_rd_valid,
  input  logic               mem_rd_ready,
  output logic [PA_W-1:0]    mem_rd_addr,
  input  logic               mem_rsp_valid,
  input  logic [PTE_W-1:0]   mem_rsp_data,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [PA_W-1:0]    res_paddr,
  output logic [FRAME_W-1:0] res_frame,
  output logic               res_writable,
  output logic               res_fault
);
  import ptw_pkg::*;

  walk_state_t        state;
  logic [VA_W-1:0]    va_q;
  logic               wr_q;
  logic [FRAME_W-1:0] base_q;
  logic [FRAME_W-1:0] frame_q;
  logic               wok_q;
  logic               fault_q;

  logic               at_l2;
  logic               chk_fault;
  logic [FRAME_W-1:0] chk_frame;
  logic               chk_wr;
  logic [PAGE_BITS-1:0] unused_root;

  assign unused_root = root_base[PAGE_BITS-1:0];
  assign at_l2       = (state == ST_READ_L2) || (state == ST_WAIT_L2);

  ptw_entry_addr #(
    .VA_W(VA_W), .PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W),
    .PTE_SHIFT(PTE_SHIFT), .FRAME_W(FRAME_W)
  ) u_addr (
    .vaddr(va_q), .table_frame(base_q), .second_level(at_l2),
    .entry_addr(mem_rd_addr)
  );

  ptw_pte_check #(
    .PTE_W(PTE_W), .PAGE_BITS(PAGE_BITS), .FRAME_W(FRAME_W)
  ) u_check (
    .entry(mem_rsp_data), .leaf_level(state == ST_WAIT_L2), .is_write(wr_q),
    .fault(chk_fault), .frame(chk_frame), .writable(chk_wr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      base_q  <= '0;
      frame_q <= '0;
      wok_q   <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          va_q    <= req_vaddr;
          wr_q    <= req_is_write;
          base_q  <= root_base[PAGE_BITS +: FRAME_W];
          fault_q <= 1'b0;
          state   <= ST_READ_L1;
        end
        ST_READ_L1: if (mem_rd_ready) state <= ST_WAIT_L1;
        ST_WAIT_L1: if (mem_rsp_valid) begin
          if (chk_fault) begin
            fault_q <= 1'b1;
            frame_q <= '0;
            wok_q   <= 1'b0;
            state   <= ST_DONE;
          end else begin
            base_q  <= chk_frame;
            state   <= ST_READ_L2;
          end
        end
        ST_READ_L2: if (mem_rd_ready) state <= ST_WAIT_L2;
        ST_WAIT_L2: if (mem_rsp_valid) begin
          fault_q <= chk_fault;
          frame_q <= chk_fault ? '0 : chk_frame;
          wok_q   <= chk_fault ? 1'b0 : chk_wr;
          state   <= ST_DONE;
        end
        ST_DONE: if (res_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready    = (state == ST_IDLE);
  assign mem_rd_valid = (state == ST_READ_L1) || (state == ST_READ_L2);
  assign res_valid    = (state == ST_DONE);
  assign res_frame    = frame_q;
  assign res_writable = wok_q;
  assign res_fault    = fault_q;
  assign res_paddr    = fault_q ? '0 : {frame_q, va_q[PAGE_BITS-1:0]};

  // R9: a pending entry read keeps its address until taken
  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_rd_addr)));

  // R10: an offered result does not move until taken
  assert_res_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=>
      (res_valid && $stable({res_paddr, res_frame, res_writable, res_fault})));

  // R8: idle never overlaps an outstanding read or result
  assert_idle_only_R8: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!mem_rd_valid && !res_valid));

  // R7: faulting results carry no translation
  assert_fault_clean_R7: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_fault) |-> (res_frame == '0 && !res_writable && res_paddr == '0));

  // R6: a successful write walk always lands on a writable page
  assert_write_perm_R6: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_fault && wr_q) |-> res_writable);

  // R4: a walk ending after the first response is always a fault
  assert_l1_stop_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_L1 && mem_rsp_valid && !mem_rsp_data[PTE_VALID_BIT]) |=>
      (res_valid && res_fault));
endmodule

// File: tb/pt_walk_engine_tb.sv
`timescale 1ns/1ps
module pt_walk_engine_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_ready, req_is_write;
  logic [31:0] req_vaddr, root_base;
  logic        mem_rd_valid, mem_rd_ready;
  logic [31:0] mem_rd_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        res_valid, res_ready, res_writable, res_fault;
  logic [31:0] res_paddr;
  logic [19:0] res_frame;

  int n_checks = 0;
  int n_fails  = 0;
  int rd_cnt   = 0;
  logic [31:0] rd_log [2];

  always #2.5 clk = ~clk;

  pt_walk_engine u_dut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_is_write(req_is_write), .root_base(root_base),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_paddr(res_paddr),
    .res_frame(res_frame), .res_writable(res_writable), .res_fault(res_fault)
  );

  function automatic logic [19:0] leaf_frame(int i1, int i2);
    return 20'((i1 * 37 + i2 * 11 + 32'h3000) & 32'hFFFFF);
  endfunction

  // memory contents, derived from the address
  function automatic logic [31:0] entry_at(logic [31:0] a);
    int fr = int'(a[31:12]);
    int ix = int'(a[11:2]);
    if (fr == 32'h10) begin
      if (ix % 3 == 0) return 32'hABCDE002;
      return {20'(32'h100 + ix), 10'h0, ix[0], 1'b1};
    end
    if (fr >= 32'h100 && fr < 32'h500) begin
      if (ix % 5 == 0) return 32'hFFFFF00A;
      return {leaf_frame(fr - 32'h100, ix), 10'h0, ix[0], 1'b1};
    end
    return 32'h0;
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  // memory responder, driven on falling edges
  initial begin
    int cyc = 0;
    int pend = 0;
    logic [31:0] paddr_q = 0;
    mem_rd_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data = 32'h0;
    forever begin
      @(negedge clk);
      cyc++;
      mem_rsp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data = entry_at(paddr_q);
        end
      end
      mem_rd_ready = (pend == 0) && (cyc % 4 != 3);
      if (!rst && mem_rd_valid && mem_rd_ready) begin
        if (rd_cnt < 2) rd_log[rd_cnt] = mem_rd_addr;
        rd_cnt++;
        paddr_q = mem_rd_addr;
        pend = 1 + (cyc % 3);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual %h expected %h", 32'd1, 32'd0);
    finish_run();
  end

  task automatic walk(logic [31:0] root, logic [31:0] va, bit wr, int stall,
                      bit hold_second);
    int i1 = int'(va[31:22]);
    int i2 = int'(va[21:12]);
    bit good_root = (root[31:12] == 20'h10);
    bit l1_bad = !good_root || (i1 % 3 == 0);
    bit l2_bad = (i2 % 5 == 0);
    bit e_wr = i2[0];
    bit e_fault = l1_bad || l2_bad || (wr && !e_wr);
    logic [19:0] e_fr = e_fault ? 20'h0 : leaf_frame(i1, i2);
    logic [31:0] e_pa = e_fault ? 32'h0 : {e_fr, va[11:0]};
    logic [31:0] a1 = {root[31:12], 12'h0} + 32'(i1 * 4);
    logic [31:0] a2 = {20'(32'h100 + i1), 12'h0} + 32'(i2 * 4);
    logic [31:0] snap;
    rd_cnt = 0;
    req_vaddr = va; req_is_write = wr; root_base = root; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    if (hold_second) begin
      req_vaddr = va ^ 32'hFFC0_0000; root_base = 32'h00020000;
    end else req_valid = 1'b0;
    check(req_ready == 1'b0, "R8 busy", {31'h0, req_ready}, 32'h0);
    while (!res_valid) @(negedge clk);
    check(res_fault == e_fault, "R4/R5/R6 fault", {31'h0, res_fault}, {31'h0, e_fault});
    check(res_paddr == e_pa, "R1 paddr", res_paddr, e_pa);
    check(res_frame == e_fr, "R7 frame", {12'h0, res_frame}, {12'h0, e_fr});
    check(res_writable == (!e_fault && e_wr), "R7 writable",
          {31'h0, res_writable}, {31'h0, !e_fault && e_wr});
    check(rd_cnt == (l1_bad ? 1 : 2), "R4/R5 read count", 32'(rd_cnt), l1_bad ? 32'd1 : 32'd2);
    check(rd_log[0] == a1, "R2 first addr", rd_log[0], a1);
    if (!l1_bad) check(rd_log[1] == a2, "R3 second addr", rd_log[1], a2);
    snap = res_paddr ^ {res_frame, res_writable, res_fault, 10'h0};
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      check(res_valid && (snap == (res_paddr ^ {res_frame, res_writable, res_fault, 10'h0})),
            "R10 hold", res_paddr, e_pa);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    req_valid = 1'b0;
    if (hold_second) begin
      check(rd_cnt == (l1_bad ? 1 : 2), "R8 no extra read", 32'(rd_cnt), l1_bad ? 32'd1 : 32'd2);
      check(req_ready == 1'b1, "R8 idle after", {31'h0, req_ready}, 32'h1);
    end
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_vaddr = 0; req_is_write = 0;
    root_base = 0; res_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R11 req_ready", {31'h0, req_ready}, 32'h1);
    check(mem_rd_valid == 1'b0, "R11 mem_rd_valid", {31'h0, mem_rd_valid}, 32'h0);
    check(res_valid == 1'b0, "R11 res_valid", {31'h0, res_valid}, 32'h0);

    for (int k1 = 0; k1 < 29; k1++) begin
      for (int k2 = 0; k2 < 29; k2++) begin
        int i1 = (k1 == 28) ? 1023 : k1 * 37;
        int i2 = (k2 == 28) ? 1023 : ((k2 * 41) & 1023);
        logic [31:0] va = {10'(i1), 10'(i2), 12'((k1 * 123 + k2 * 7) | ((k2 == 5) ? 4095 : 0))};
        logic [31:0] rt = (k2 % 2 == 1) ? 32'h00010ABC : 32'h00010000;
        int st = ((k1 + k2) % 7 == 0) ? 2 : 0;
        walk(rt, va, 1'b0, st, 1'b0);
        walk(rt, va, 1'b1, st, 1'b0);
      end
    end

    // R2: a different root (all entries invalid) is really used
    for (int k = 0; k < 8; k++)
      walk(32'h00020000, {10'(k * 131), 10'(k * 3 + 1), 12'h5A5}, k[0], 0, 1'b0);

    // R8: a second request held during a walk is not taken
    walk(32'h00010000, {10'd1, 10'd3, 12'h123}, 1'b0, 1, 1'b1);
    walk(32'h00010000, {10'd3, 10'd3, 12'h123}, 1'b1, 0, 1'b1);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule